// File: doc/BRIEF.md
# Eight-Channel DMA Register Bank

This block holds the software-visible state of an eight-channel DMA engine that lives inside a peripheral's register space. Each channel has a packed control word, a 32-bit address register and a 32-bit count register. The control word carries these fields:

- enable
- direction
- mode select
- interrupt enable
- endpoint number
- a sticky bus-error flag
- a burst type

One shared byte collects completion and fault events from all channels, and a single interrupt line summarises them.

Software writes a channel's address and count first and its control word last. A control write with the enable bit set sends a one-cycle start pulse to that channel's transfer engine. The engine then reports progress back: it loads the current address and the remaining count, and it signals completion or a bus error. Software works out the bytes moved as the current address minus the start address it programmed. Writing zero to all three registers stops and clears a channel.

Top module: `dmab_regbank`

## Requirements
- R1: After synchronous reset, every register reads 0 and every output, `irq` included, is 0.
- R2: Channel n owns a 16-byte slot at 0x200 + 16·n. The control word is at +0x4, the address at +0x8 and the count at +0xC. Address and count read back the full 32-bit value written, combinationally on `reg_rdata`.
- R3: The control word layout is: bit 0 enable, bit 1 direction (1 = transmit), bit 2 mode 1, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error, bits 10:9 burst (0 unspecified, 1 four-beat, 2 eight-beat, 3 sixteen-beat). Bits 15:11 read 0. The fields appear on the `ch_*` outputs the cycle after the write.
- R4: A control write with bit 0 = 1 gives exactly one `ch_start` pulse for that channel in the following cycle. A control write with bit 0 = 0 gives none.
- R5: `eng_upd[n]` loads `eng_cur_addr` and `eng_remain` into channel n's address and count registers. A software write to the same register in the same cycle takes precedence over the engine update.
- R6: `eng_done[n]` or `eng_buserr[n]` clears channel n's enable bit, unless a control write lands in the same cycle. `eng_buserr[n]` sets control bit 8.
- R7: Bit 8 of the control word is read-only. Writing 1 to it does not set it, and any control write clears it. A bus error in the same cycle as a control write leaves it set.
- R8: The status byte at 0x200 shows bit n set once channel n has completed or faulted. A read of 0x200 clears the pending bits, but an event arriving in that same cycle stays pending. Writes to 0x200 have no effect.
- R9: `irq` is 1 exactly while some status bit n is set and channel n's interrupt-enable bit (bit 3) is 1.
- R10: Writing 0 to a running channel's control word drops its enable output without a start pulse.
- R11: The following addresses read 0, and writes to them change nothing:
  - offset 0 of channels 1 to 7
  - offsets that are not 0x0, 0x4, 0x8 or 0xC
  - any address outside 0x200 to 0x27F

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on 0x200) |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| eng_upd | input | 8 | Per-channel progress update strobe |
| eng_cur_addr | input | 256 | Per-channel current address, channel n at [32n+31:32n] |
| eng_remain | input | 256 | Per-channel remaining count |
| eng_done | input | 8 | Per-channel completion pulse |
| eng_buserr | input | 8 | Per-channel bus-error pulse |
| ch_start | output | 8 | One-cycle start pulse per channel |
| ch_en | output | 8 | Enable bit per channel |
| ch_tx | output | 8 | Direction bit per channel (1 = transmit) |
| ch_mode1 | output | 8 | Mode-1 select per channel |
| ch_ep | output | 32 | Endpoint number, 4 bits per channel |
| ch_burst | output | 16 | Burst type, 2 bits per channel |
| ch_addr | output | 256 | Address register per channel |
| ch_count | output | 256 | Count register per channel |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted control or address register appears on the matching `ch_*` output one clock after it goes wrong. It also appears on `reg_rdata` in the same cycle the slot is addressed, so the bench compares every channel's outputs against its model on every clock. A lost or stuck status bit shows on `irq` at once when that channel's interrupt is enabled. Otherwise it shows on the next status read, and reads are issued both alone and in the same cycle as new events. A wrong priority between a software write and an engine update or fault is caught in the cycle after the collision, because the bench forces those collisions directly.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    localparam int SLOT_BITS = 4;
    localparam logic [SLOT_BITS-1:0] OFF_STAT = 4'h0;
    localparam logic [SLOT_BITS-1:0] OFF_CTRL = 4'h4;
    localparam logic [SLOT_BITS-1:0] OFF_ADDR = 4'h8;
    localparam logic [SLOT_BITS-1:0] OFF_CNT  = 4'hC;
    localparam int CTRL_W = 11;

    typedef enum logic [1:0] {
        BURST_ANY = 2'd0,
        BURST_4   = 2'd1,
        BURST_8   = 2'd2,
        BURST_16  = 2'd3
    } burst_e;

    // Packed MSB first so the struct is the control word bits 10:0.
    typedef struct packed {
        burst_e     burst;
        logic       berr;
        logic [3:0] ep;
        logic       ie;
        logic       mode1;
        logic       tx;
        logic       en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.burst = burst_e'(w[10:9]);
        c.berr  = 1'b0;
        c.ep    = w[7:4];
        c.ie    = w[3];
        c.mode1 = w[2];
        c.tx    = w[1];
        c.en    = w[0];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_to_word(ctrl_t c);
        return {{(16-CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
    import dmab_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200,
    localparam int CH_W = $clog2(NCH),
    localparam int WIN_BITS = SLOT_BITS + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              stat_hit,
    output logic              ctrl_hit,
    output logic              addr_hit,
    output logic              cnt_hit,
    output logic [CH_W-1:0]   ch_sel
);
    logic                 in_win;
    logic [SLOT_BITS-1:0] off;

    always_comb begin
        in_win   = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        ch_sel   = addr[SLOT_BITS +: CH_W];
        off      = addr[SLOT_BITS-1:0];
        stat_hit = in_win && (ch_sel == '0) && (off == OFF_STAT);
        ctrl_hit = in_win && (off == OFF_CTRL);
        addr_hit = in_win && (off == OFF_ADDR);
        cnt_hit  = in_win && (off == OFF_CNT);
    end
endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
    import dmab_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          eng_upd,
    input  logic [DW-1:0] eng_addr,
    input  logic [DW-1:0] eng_cnt,
    input  logic          eng_done,
    input  logic          eng_err,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] cnt_q,
    output logic          start
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            start  <= 1'b0;
        end else begin
            start <= wr_ctrl && wdata[0];
            if (wr_ctrl)
                ctrl_q <= ctrl_from_word(wdata[CTRL_W-1:0]);
            else if (eng_done || eng_err)
                ctrl_q.en <= 1'b0;
            if (eng_err)
                ctrl_q.berr <= 1'b1;
            if (wr_addr)
                addr_q <= wdata;
            else if (eng_upd)
                addr_q <= eng_addr;
            if (wr_cnt)
                cnt_q <= wdata;
            else if (eng_upd)
                cnt_q <= eng_cnt;
        end
    end

    a_r4_start_has_enable: assert property (@(posedge clk) disable iff (rst)
        start |-> ctrl_q.en);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        eng_err |=> ctrl_q.berr);
    a_r6_event_stops: assert property (@(posedge clk) disable iff (rst)
        ((eng_done || eng_err) && !wr_ctrl) |=> !ctrl_q.en);
    a_r5_sw_addr_wins: assert property (@(posedge clk) disable iff (rst)
        wr_addr |=> addr_q == $past(wdata));
    a_r5_sw_cnt_wins: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/dmab_irq.sv
module dmab_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           rd_clr,
    input  logic [NCH-1:0] ie,
    output logic [NCH-1:0] pend,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (rd_clr ? '0 : pend) | evt;
    end

    assign irq = |(pend & ie);

    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && evt == '0) |=> pend == '0);
    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq);
endmodule

// File: rtl/dmab_regbank.sv
module dmab_regbank
    import dmab_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW = 32,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NCH-1:0]    eng_upd,
    input  logic [NCH*DW-1:0] eng_cur_addr,
    input  logic [NCH*DW-1:0] eng_remain,
    input  logic [NCH-1:0]    eng_done,
    input  logic [NCH-1:0]    eng_buserr,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_tx,
    output logic [NCH-1:0]    ch_mode1,
    output logic [NCH*4-1:0]  ch_ep,
    output logic [NCH*2-1:0]  ch_burst,
    output logic [NCH*DW-1:0] ch_addr,
    output logic [NCH*DW-1:0] ch_count,
    output logic              irq
);
    logic            stat_hit, ctrl_hit, addr_hit, cnt_hit;
    logic [CH_W-1:0] ch_sel;
    logic [NCH-1:0]  evt, pend, ie;
    logic            rd_clr;
    ctrl_t           ctrl_a [NCH];
    logic [DW-1:0]   addr_a [NCH];
    logic [DW-1:0]   cnt_a  [NCH];

    dmab_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .WIN_BASE(WIN_BASE)) u_dec (
        .addr(reg_addr), .stat_hit(stat_hit), .ctrl_hit(ctrl_hit),
        .addr_hit(addr_hit), .cnt_hit(cnt_hit), .ch_sel(ch_sel)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dmab_chan #(.DW(DW)) u_chan (
            .clk(clk), .rst(rst),
            .wr_ctrl(reg_wr && ctrl_hit && ch_sel == CH_W'(n)),
            .wr_addr(reg_wr && addr_hit && ch_sel == CH_W'(n)),
            .wr_cnt (reg_wr && cnt_hit  && ch_sel == CH_W'(n)),
            .wdata(reg_wdata),
            .eng_upd(eng_upd[n]),
            .eng_addr(eng_cur_addr[n*DW +: DW]),
            .eng_cnt(eng_remain[n*DW +: DW]),
            .eng_done(eng_done[n]),
            .eng_err(eng_buserr[n]),
            .ctrl_q(ctrl_a[n]),
            .addr_q(addr_a[n]),
            .cnt_q(cnt_a[n]),
            .start(ch_start[n])
        );
        assign ch_en[n]            = ctrl_a[n].en;
        assign ch_tx[n]            = ctrl_a[n].tx;
        assign ch_mode1[n]         = ctrl_a[n].mode1;
        assign ch_ep[n*4 +: 4]     = ctrl_a[n].ep;
        assign ch_burst[n*2 +: 2]  = ctrl_a[n].burst;
        assign ch_addr[n*DW +: DW] = addr_a[n];
        assign ch_count[n*DW +: DW] = cnt_a[n];
        assign ie[n]               = ctrl_a[n].ie;
        assign evt[n]              = eng_done[n] || eng_buserr[n];
    end

    assign rd_clr = reg_rd && stat_hit;

    dmab_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst(rst), .evt(evt), .rd_clr(rd_clr),
        .ie(ie), .pend(pend), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (stat_hit)
            reg_rdata = {{(DW-NCH){1'b0}}, pend};
        else if (ctrl_hit)
            reg_rdata = {{(DW-16){1'b0}}, ctrl_to_word(ctrl_a[ch_sel])};
        else if (addr_hit)
            reg_rdata = addr_a[ch_sel];
        else if (cnt_hit)
            reg_rdata = cnt_a[ch_sel];
    end

    a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && stat_hit && !reg_rd && evt == '0) |=> $stable(pend));
endmodule

// File: tb/dmab_regbank_tb.sv
module dmab_regbank_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCH = 8;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [7:0] eng_upd, eng_done, eng_buserr;
    logic [255:0] eng_cur_addr, eng_remain;
    logic [7:0] ch_start, ch_en, ch_tx, ch_mode1;
    logic [31:0] ch_ep;
    logic [15:0] ch_burst;
    logic [255:0] ch_addr, ch_count;
    logic irq;

    always #2.5 clk = ~clk;

    dmab_regbank u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_upd(eng_upd), .eng_cur_addr(eng_cur_addr), .eng_remain(eng_remain),
        .eng_done(eng_done), .eng_buserr(eng_buserr),
        .ch_start(ch_start), .ch_en(ch_en), .ch_tx(ch_tx), .ch_mode1(ch_mode1),
        .ch_ep(ch_ep), .ch_burst(ch_burst), .ch_addr(ch_addr),
        .ch_count(ch_count), .irq(irq)
    );

    // Behavioural model
    bit [15:0] m_ctrl [NCH];
    bit [31:0] m_addr [NCH];
    bit [31:0] m_cnt  [NCH];
    bit [7:0]  m_pend;
    bit [7:0]  m_start;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_tag = "R2";

    task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rd(bit [11:0] a);
        int ch, off;
        if (a < 12'h200 || a > 12'h27F) return 32'h0;
        ch  = int'((a - 12'h200) >> 4);
        off = int'(a & 12'hF);
        if (off == 0 && ch == 0) return {24'h0, m_pend};
        if (off == 4) return {16'h0, m_ctrl[ch]};
        if (off == 8) return m_addr[ch];
        if (off == 12) return m_cnt[ch];
        return 32'h0;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        for (int n = 0; n < NCH; n++)
            if (m_pend[n] && m_ctrl[n][3]) r = 1;
        return r;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NCH; n++) begin
            m_ctrl[n] = 0; m_addr[n] = 0; m_cnt[n] = 0;
        end
        m_pend = 0; m_start = 0;
    endtask

    task automatic model_step();
        bit [7:0] evt;
        evt = eng_done | eng_buserr;
        for (int n = 0; n < NCH; n++) begin
            bit [11:0] slot;
            bit wc, wa, wn;
            slot = 12'h200 + 12'(n * 16);
            wc = reg_wr && reg_addr == slot + 12'h4;
            wa = reg_wr && reg_addr == slot + 12'h8;
            wn = reg_wr && reg_addr == slot + 12'hC;
            m_start[n] = wc && reg_wdata[0];
            if (wc) m_ctrl[n] = reg_wdata[15:0] & 16'h06FF;
            else if (evt[n]) m_ctrl[n][0] = 1'b0;
            if (eng_buserr[n]) m_ctrl[n][8] = 1'b1;
            if (wa) m_addr[n] = reg_wdata;
            else if (eng_upd[n]) m_addr[n] = eng_cur_addr[n*32 +: 32];
            if (wn) m_cnt[n] = reg_wdata;
            else if (eng_upd[n]) m_cnt[n] = eng_remain[n*32 +: 32];
        end
        m_pend = ((reg_rd && reg_addr == 12'h200) ? 8'h0 : m_pend) | evt;
    endtask

    task automatic cmp_outputs();
        logic [7:0] e_en, e_tx, e_md;
        logic [31:0] e_ep;
        logic [15:0] e_bu;
        logic [255:0] e_ad, e_ct;
        for (int n = 0; n < NCH; n++) begin
            e_en[n] = m_ctrl[n][0];
            e_tx[n] = m_ctrl[n][1];
            e_md[n] = m_ctrl[n][2];
            e_ep[n*4 +: 4] = m_ctrl[n][7:4];
            e_bu[n*2 +: 2] = m_ctrl[n][10:9];
            e_ad[n*32 +: 32] = m_addr[n];
            e_ct[n*32 +: 32] = m_cnt[n];
        end
        chk("R4", "ch_start", 256'(ch_start), 256'(m_start));
        chk("R3", "ch_en", 256'(ch_en), 256'(e_en));
        chk("R3", "ch_tx", 256'(ch_tx), 256'(e_tx));
        chk("R3", "ch_mode1", 256'(ch_mode1), 256'(e_md));
        chk("R3", "ch_ep", 256'(ch_ep), 256'(e_ep));
        chk("R3", "ch_burst", 256'(ch_burst), 256'(e_bu));
        chk("R5", "ch_addr", ch_addr, e_ad);
        chk("R5", "ch_count", ch_count, e_ct);
    endtask

    // Inputs are already set at a falling edge.
    task automatic step();
        #1;
        chk(cur_tag, "reg_rdata", 256'(reg_rdata), 256'(exp_rd(reg_addr)));
        chk("R9", "irq", 256'(irq), 256'(exp_irq()));
        model_step();
        @(posedge clk);
        @(negedge clk);
        cmp_outputs();
    endtask

    task automatic clr_in();
        reg_wr = 0; reg_rd = 0; reg_addr = 12'h0; reg_wdata = 0;
        eng_upd = 0; eng_done = 0; eng_buserr = 0;
        eng_cur_addr = '0; eng_remain = '0;
    endtask

    task automatic do_wr(bit [11:0] a, bit [31:0] d, string tag);
        clr_in(); cur_tag = tag;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic do_rd(bit [11:0] a, string tag);
        clr_in(); cur_tag = tag;
        reg_rd = 1; reg_addr = a;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        clr_in();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "irq", 256'(irq), 256'(0));
        chk("R1", "ch_en", 256'(ch_en), 256'(0));
        chk("R1", "ch_addr", ch_addr, 256'(0));
        do_rd(12'h200, "R1");
        do_rd(12'h234, "R1");
        do_rd(12'h278, "R1");

        // R2: address/count of every slot
        for (int n = 0; n < NCH; n++) begin
            do_wr(12'h208 + 12'(n * 16), 32'hA000_0000 + 32'(n * 32'h1111), "R2");
            do_wr(12'h20C + 12'(n * 16), 32'h0000_0100 + 32'(n), "R2");
        end
        for (int n = 0; n < NCH; n++) begin
            do_rd(12'h208 + 12'(n * 16), "R2");
            do_rd(12'h20C + 12'(n * 16), "R2");
        end

        // R3/R4/R7: control on ch3, bit 8 and upper bits written as 1
        do_wr(12'h234, 32'hFFFF_F75F, "R3");
        do_rd(12'h234, "R7");
        // R4: no start when bit 0 is 0
        do_wr(12'h244, 32'h0000_0226, "R4");
        do_rd(12'h244, "R3");

        // R5: engine update then readback; collision with software write
        clr_in(); cur_tag = "R5";
        eng_upd[3] = 1; eng_cur_addr[3*32 +: 32] = 32'hA000_3373;
        eng_remain[3*32 +: 32] = 32'h0000_0040;
        step();
        do_rd(12'h238, "R5");
        clr_in(); cur_tag = "R5";
        reg_wr = 1; reg_addr = 12'h23C; reg_wdata = 32'h0000_0777;
        eng_upd[3] = 1; eng_remain[3*32 +: 32] = 32'h0000_0011;
        eng_cur_addr[3*32 +: 32] = 32'hA000_4000;
        step();
        do_rd(12'h23C, "R5");
        do_rd(12'h238, "R5");

        // R6/R8/R9: done on ch3 (ie=1) -> pend bit 3, enable dropped, irq
        clr_in(); cur_tag = "R6"; eng_done[3] = 1; step();
        do_rd(12'h234, "R6");
        // R9: ch4 has ie=0; pending alone keeps irq as model says
        clr_in(); cur_tag = "R9"; eng_done[4] = 1; step();
        // R8: status write ignored
        do_wr(12'h200, 32'h0000_0000, "R8");
        // R8: read clears; simultaneous event on ch1 stays
        clr_in(); cur_tag = "R8"; reg_rd = 1; reg_addr = 12'h200; eng_done[1] = 1; step();
        do_rd(12'h200, "R8");
        do_rd(12'h200, "R8");

        // R7: bus error sticky, cleared by control write, kept on collision
        do_wr(12'h254, 32'h0000_0009, "R7");
        clr_in(); cur_tag = "R7"; eng_buserr[5] = 1; step();
        do_rd(12'h254, "R7");
        do_wr(12'h254, 32'h0000_0009, "R7");
        do_rd(12'h254, "R7");
        clr_in(); cur_tag = "R7";
        reg_wr = 1; reg_addr = 12'h254; reg_wdata = 32'h0000_0009; eng_buserr[5] = 1;
        step();
        do_rd(12'h254, "R7");
        do_rd(12'h200, "R8");

        // R10: zero write stops a running channel
        do_wr(12'h264, 32'h0000_0003, "R10");
        do_wr(12'h264, 32'h0000_0000, "R10");
        do_wr(12'h268, 32'h0, "R10");
        do_wr(12'h26C, 32'h0, "R10");
        do_rd(12'h264, "R10");

        // R11: unmapped locations
        do_wr(12'h210, 32'hFFFF_FFFF, "R11");
        do_wr(12'h206, 32'hFFFF_FFFF, "R11");
        do_wr(12'h280, 32'hFFFF_FFFF, "R11");
        do_wr(12'h1FC, 32'hFFFF_FFFF, "R11");
        do_rd(12'h210, "R11");
        do_rd(12'h206, "R11");
        do_rd(12'h280, "R11");
        do_rd(12'h1FC, "R11");

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op, ch, off;
            clr_in();
            op  = int'($urandom_range(0, 9));
            ch  = int'($urandom_range(0, 7));
            off = 4 * int'($urandom_range(0, 3));
            reg_addr = 12'h200 + 12'(ch * 16 + off);
            if (op < 4) begin
                reg_wr = 1; reg_wdata = $urandom();
                cur_tag = (off == 4) ? "R3" : "R2";
            end else if (op < 7) begin
                reg_rd = 1;
                cur_tag = (off == 0) ? "R8" : "R2";
            end else if (op == 7) begin
                reg_addr = 12'(int'($urandom_range(12'h1E0, 12'h2A0)));
                reg_rd = 1; cur_tag = "R11";
            end else begin
                cur_tag = "R6";
            end
            if ($urandom_range(0, 3) == 0) eng_done = 8'($urandom());
            if ($urandom_range(0, 7) == 0) eng_buserr = 8'($urandom());
            if ($urandom_range(0, 3) == 0) begin
                eng_upd = 8'($urandom());
                for (int n = 0; n < NCH; n++) begin
                    eng_cur_addr[n*32 +: 32] = $urandom();
                    eng_remain[n*32 +: 32] = $urandom();
                end
            end
            step();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule